// File: doc/BRIEF.md
# Countdown Compare System Timer

This block keeps a free-running 64-bit system count that steps once for every cycle in which a fixed-rate tick strobe is high. The strobe is independent of the core clock. One compare timer sits beside the count. Software programs the timer with a relative distance. The block turns that distance into an absolute compare point by adding it to the count at the moment of the write.

When the count reaches or passes the compare point, a status bit sets. If the timer is enabled and not masked, a level interrupt is raised. This interrupt is meant to be wired as a core-private line, such as ID 30 on the interrupt controller. Reading the distance register back returns how far away the compare point still is, and that value goes negative after expiry. Writing the same distance again arms the next period of equal length.

Access goes through a small synchronous register port. It holds a read-only rate word, the control word, the distance word and the two halves of the count.

Top module: `sys_timer`

## Requirements
- R1: Address 0 reads the tick rate in Hz, 62,500,000 by default, and a write to it has no effect.
- R2: The count steps by exactly one on each clock in which `tick_en` is high and holds otherwise. It wraps from all ones to zero. Address 3 reads its low 32 bits and address 4 its high 32 bits.
- R3: Writing N to address 2 sets the compare point to count + N. Status is met while the count, compared as unsigned, is at or above the compare point. This also applies when the compare point has wrapped past zero.
- R4: Address 1 is control. Bit 0 enables the timer, bit 1 masks the interrupt and bit 2 reads the status. Bit 2 is read-only, so writing it changes nothing. Control resets to 0.
- R5: With the mask set, `irq_o` stays low, while status still reads 1 when the condition is met.
- R6: `irq_o` is high exactly when the timer is enabled, status is met and the mask is clear. It stays high as long as that remains true.
- R7: Reading address 2 returns the low 32 bits of compare point minus count. This value is negative (two's complement) after expiry.
- R8: While enable is 0, status reads 0 and `irq_o` is low.
- R9: Rewriting address 2 with the same N after an interrupt clears the interrupt. The interrupt returns after exactly N further ticks.
- R10: The written value is sign-extended from 32 bits before the add, so a negative N gives an already-met condition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Fixed-rate count strobe |
| reg_addr | input | 3 | Register word address |
| reg_we | input | 1 | Write strobe for the addressed register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the addressed register (combinational) |
| irq_o | output | 1 | Level timer interrupt |

## Verification
The bench keeps the default rate and widths. It overrides the count's reset value to 64'hFFFF_FFFF_FFFF_FF00 so that the top of the 64-bit range lies a few hundred ticks away. This brings two cases within reach of a short run. The first is a compare point that wraps past zero and is therefore already met under unsigned comparison. The second is the carry into the high count word, which returns it to zero.

// File: rtl/sys_timer_pkg.sv
package sys_timer_pkg;

    localparam int REG_AW = 3;
    localparam int REG_DW = 32;

    typedef enum logic [REG_AW-1:0] {
        ADDR_RATE   = 3'd0,
        ADDR_CTRL   = 3'd1,
        ADDR_DELTA  = 3'd2,
        ADDR_CNT_LO = 3'd3,
        ADDR_CNT_HI = 3'd4
    } reg_addr_e;

    localparam int CTRL_EN_BIT   = 0;
    localparam int CTRL_MASK_BIT = 1;
    localparam int CTRL_STAT_BIT = 2;

endpackage

// File: rtl/sys_timer_counter.sv
module sys_timer_counter #(
    parameter int          CNT_W    = 64,
    parameter logic [63:0] CNT_INIT = 64'd0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    output logic [CNT_W-1:0] count_o
);

    typedef struct packed {
        logic [CNT_W-1:0] count;
    } cnt_state_t;

    cnt_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (tick_en) begin
            state_d.count = state_q.count + {{(CNT_W-1){1'b0}}, 1'b1};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q.count <= CNT_INIT[CNT_W-1:0];
        end else begin
            state_q <= state_d;
        end
    end

    assign count_o = state_q.count;

    // R2: a strobe moves the count by one
    a_r2_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        tick_en |=> count_o == $past(count_o) + {{(CNT_W-1){1'b0}}, 1'b1});

    // R2: no strobe, no movement
    a_r2_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_en |=> $stable(count_o));

endmodule

// File: rtl/sys_timer_compare.sv
module sys_timer_compare #(
    parameter int CNT_W = 64,
    parameter int DW    = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic [CNT_W-1:0] count_i,
    input  logic             wr_delta_i,
    input  logic             wr_ctrl_i,
    input  logic [DW-1:0]    wdata_i,
    output logic             en_o,
    output logic             mask_o,
    output logic             met_o,
    output logic [DW-1:0]    remain_o
);

    import sys_timer_pkg::*;

    localparam int EXT_W = CNT_W - DW;

    typedef struct packed {
        logic [CNT_W-1:0] cmp;
        logic             en;
        logic             mask;
    } cmp_state_t;

    cmp_state_t state_d, state_q;
    logic [CNT_W-1:0] delta_ext;

    assign delta_ext = {{EXT_W{wdata_i[DW-1]}}, wdata_i};

    always_comb begin
        state_d = state_q;
        if (wr_delta_i) begin
            state_d.cmp = count_i + delta_ext;
        end
        if (wr_ctrl_i) begin
            state_d.en   = wdata_i[CTRL_EN_BIT];
            state_d.mask = wdata_i[CTRL_MASK_BIT];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q.cmp  <= '0;
            state_q.en   <= 1'b0;
            state_q.mask <= 1'b0;
        end else begin
            state_q <= state_d;
        end
    end

    assign en_o     = state_q.en;
    assign mask_o   = state_q.mask;
    assign met_o    = state_q.en && (count_i >= state_q.cmp);
    assign remain_o = state_q.cmp[DW-1:0] - count_i[DW-1:0];

    // R8: a disabled timer never reports a met condition
    a_r8_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !en_o |-> !met_o);

    // R3: once met, a later tick short of wrap keeps it met when nothing is written
    a_r3_met_persists: assert property (@(posedge clk) disable iff (!rst_n)
        (met_o && tick_en && !wr_delta_i && !wr_ctrl_i && !(&count_i)) |=> met_o);

endmodule

// File: rtl/sys_timer_regs.sv
module sys_timer_regs #(
    parameter int CNT_W   = 64,
    parameter int DW      = 32,
    parameter int RATE_HZ = 62_500_000
) (
    input  logic [2:0]       addr_i,
    input  logic             we_i,
    input  logic [CNT_W-1:0] count_i,
    input  logic             en_i,
    input  logic             mask_i,
    input  logic             met_i,
    input  logic [DW-1:0]    remain_i,
    output logic             wr_delta_o,
    output logic             wr_ctrl_o,
    output logic [DW-1:0]    rdata_o
);

    import sys_timer_pkg::*;

    localparam logic [DW-1:0] RATE_WORD = DW'(RATE_HZ);

    reg_addr_e sel;
    assign sel = reg_addr_e'(addr_i);

    assign wr_delta_o = we_i && (sel == ADDR_DELTA);
    assign wr_ctrl_o  = we_i && (sel == ADDR_CTRL);

    always_comb begin
        rdata_o = '0;
        case (sel)
            ADDR_RATE:   rdata_o = RATE_WORD;
            ADDR_CTRL: begin
                rdata_o[CTRL_EN_BIT]   = en_i;
                rdata_o[CTRL_MASK_BIT] = mask_i;
                rdata_o[CTRL_STAT_BIT] = met_i;
            end
            ADDR_DELTA:  rdata_o = remain_i;
            ADDR_CNT_LO: rdata_o = count_i[DW-1:0];
            ADDR_CNT_HI: rdata_o = count_i[DW +: DW];
            default:     rdata_o = '0;
        endcase
    end

endmodule

// File: rtl/sys_timer.sv
module sys_timer #(
    parameter int          CNT_W    = 64,
    parameter int          RATE_HZ  = 62_500_000,
    parameter logic [63:0] CNT_INIT = 64'd0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tick_en,
    input  logic [2:0]  reg_addr,
    input  logic        reg_we,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        irq_o
);

    localparam int DW = sys_timer_pkg::REG_DW;

    logic [CNT_W-1:0] count;
    logic             wr_delta, wr_ctrl;
    logic             en, mask, met;
    logic [DW-1:0]    remain;

    sys_timer_counter #(.CNT_W(CNT_W), .CNT_INIT(CNT_INIT)) u_counter (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_en (tick_en),
        .count_o (count)
    );

    sys_timer_regs #(.CNT_W(CNT_W), .DW(DW), .RATE_HZ(RATE_HZ)) u_regs (
        .addr_i     (reg_addr),
        .we_i       (reg_we),
        .count_i    (count),
        .en_i       (en),
        .mask_i     (mask),
        .met_i      (met),
        .remain_i   (remain),
        .wr_delta_o (wr_delta),
        .wr_ctrl_o  (wr_ctrl),
        .rdata_o    (reg_rdata)
    );

    sys_timer_compare #(.CNT_W(CNT_W), .DW(DW)) u_compare (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_en    (tick_en),
        .count_i    (count),
        .wr_delta_i (wr_delta),
        .wr_ctrl_i  (wr_ctrl),
        .wdata_i    (reg_wdata),
        .en_o       (en),
        .mask_o     (mask),
        .met_o      (met),
        .remain_o   (remain)
    );

    assign irq_o = en && met && !mask;

    // R5: a set mask keeps the line low
    a_r5_mask_silences: assert property (@(posedge clk) disable iff (!rst_n)
        mask |-> !irq_o);

    // R6: a raised line holds while nothing is written and the count moves on without wrap
    a_r6_level_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && !reg_we && !(&count)) |=> irq_o);

endmodule

// File: tb/tb_sys_timer.sv
module tb_sys_timer;

    localparam int          CLK_PERIOD = 10;
    localparam logic [63:0] INIT_CNT   = 64'hFFFF_FFFF_FFFF_FF00;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic        reg_we = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq_o;

    always #(CLK_PERIOD/2) clk = ~clk;

    sys_timer #(.CNT_INIT(INIT_CNT)) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_en   (tick_en),
        .reg_addr  (reg_addr),
        .reg_we    (reg_we),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .irq_o     (irq_o)
    );

    typedef struct {
        string       tag;
        bit          on_irq;
        logic [31:0] exp;
    } item_t;

    item_t q[$];
    int    total = 0;
    int    bad = 0;
    bit    probe = 1'b0;
    bit    finished = 1'b0;

    logic [63:0] cnt_m = INIT_CNT;
    logic [63:0] cmp_m = 64'd0;

    // monitor: pops and compares away from the active edge
    always @(negedge clk) begin
        if (probe && q.size() > 0) begin
            item_t it;
            logic [31:0] act;
            it = q.pop_front();
            act = it.on_irq ? {31'd0, irq_o} : reg_rdata;
            total++;
            if (act !== it.exp) begin
                bad++;
                $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
            end
        end
    end

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        @(posedge clk); #1;
        reg_we = 1'b0;
    endtask

    task automatic set_delta(input logic [31:0] n);
        wr(3'd2, n);
        cmp_m = cnt_m + {{32{n[31]}}, n};
    endtask

    task automatic exp_rd(input logic [2:0] a, input logic [31:0] e, input string tag);
        item_t it;
        @(posedge clk); #1;
        reg_addr = a;
        it.tag = tag; it.on_irq = 1'b0; it.exp = e;
        q.push_back(it);
        probe = 1'b1;
        @(negedge clk); #1;
        probe = 1'b0;
    endtask

    task automatic exp_irq(input bit e, input string tag);
        item_t it;
        @(posedge clk); #1;
        it.tag = tag; it.on_irq = 1'b1; it.exp = {31'd0, e};
        q.push_back(it);
        probe = 1'b1;
        @(negedge clk); #1;
        probe = 1'b0;
    endtask

    task automatic ticks(input int n);
        if (n > 0) begin
            @(posedge clk); #1;
            tick_en = 1'b1;
            repeat (n) @(posedge clk);
            #1 tick_en = 1'b0;
            cnt_m = cnt_m + 64'(n);
        end
    endtask

    function automatic logic [31:0] remain_m();
        logic [63:0] diff;
        diff = cmp_m - cnt_m;
        return diff[31:0];
    endfunction

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // reset state
        exp_rd(3'd0, 32'd62_500_000, "R1 rate after reset");
        exp_rd(3'd1, 32'd0,          "R4 control after reset");
        exp_irq(1'b0,                "R6 irq after reset");
        exp_rd(3'd3, INIT_CNT[31:0], "R2 count low after reset");

        // R1: write to rate word ignored
        wr(3'd0, 32'h1234_5678);
        exp_rd(3'd0, 32'd62_500_000, "R1 rate write ignored");

        // R2: hold without strobe, step with it
        repeat (5) @(posedge clk);
        exp_rd(3'd3, cnt_m[31:0], "R2 hold without tick");
        ticks(7);
        exp_rd(3'd3, cnt_m[31:0], "R2 seven ticks");

        // R4: status bit not writable
        wr(3'd1, 32'h4);
        exp_rd(3'd1, 32'd0, "R4 status write no effect");

        // R3 / R7 / R6: arm 10 ticks
        wr(3'd1, 32'h1);
        set_delta(32'd10);
        exp_rd(3'd2, 32'd10, "R7 remaining after arm");
        exp_rd(3'd1, 32'h1,  "R3 not met right after arm");
        ticks(9);
        exp_rd(3'd2, 32'd1,  "R7 one tick left");
        exp_irq(1'b0,        "R3 not met one short");
        ticks(1);
        exp_rd(3'd1, 32'h5,  "R3 met at compare point");
        exp_irq(1'b1,        "R6 irq at compare point");
        ticks(3);
        exp_rd(3'd2, 32'hFFFF_FFFD, "R7 negative after expiry");
        exp_irq(1'b1,        "R6 irq level holds");

        // R5: mask
        wr(3'd1, 32'h3);
        exp_irq(1'b0,        "R5 mask lowers irq");
        exp_rd(3'd1, 32'h7,  "R5 status kept under mask");

        // R8: disable
        wr(3'd1, 32'h0);
        exp_rd(3'd1, 32'h0,  "R8 status zero when disabled");
        exp_irq(1'b0,        "R8 irq low when disabled");

        // R9: re-arm with the same distance
        wr(3'd1, 32'h1);
        exp_irq(1'b1,        "R9 expired before rewrite");
        set_delta(32'd10);
        exp_irq(1'b0,        "R9 rewrite clears irq");
        ticks(9);
        exp_irq(1'b0,        "R9 still waiting");
        ticks(1);
        exp_irq(1'b1,        "R9 fires after same period");

        // R10: negative distance
        set_delta(32'hFFFF_FFFB);
        exp_rd(3'd1, 32'h5,  "R10 negative distance already met");
        exp_rd(3'd2, 32'hFFFF_FFFB, "R10 remaining reads minus five");

        // R3: compare point wraps past zero, unsigned compare already met
        ticks(int'(8'hF0 - cnt_m[7:0]));
        set_delta(32'h0000_0200);
        exp_rd(3'd1, 32'h5,  "R3 wrapped compare met unsigned");

        // R2: carry out of the top returns the high word to zero
        ticks(32'h20);
        exp_rd(3'd4, 32'd0,  "R2 high word after wrap");
        exp_rd(3'd3, 32'h10, "R2 low word after wrap");
        exp_rd(3'd1, 32'h1,  "R3 not met after count wrapped");
        exp_rd(3'd2, remain_m(), "R7 remaining after wrap");

        @(posedge clk); #1;
        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule